// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a two-port synchronous static RAM. Port A and port B share one clock and each can read or write any word of the array in every cycle, independently of the other. All address, control and write-data inputs of a port are captured in input registers on a rising edge and used one edge later. A port that is enabled and not writing performs a read.

Each port owns a burst address counter, and the counter supplies the access address. The counter can be cleared to zero, loaded from the port's address bus, stepped by one, or held, so a burst of sequential words needs only one address. A single mode input chooses how reads leave the block. In flow-through mode the read word appears one edge after the inputs are captured. In pipelined mode an extra output register adds one more edge of latency. A port that is not enabled powers down: its read-valid flag is low and its read data is zero.

The array depth is 2^ADDR_W words of DATA_W bits. A 14-bit, 36-bit configuration gives 16K words. The default is 10 address bits, which keeps the inferred array small.

Top module: `dual_burst_sram`

## Requirements
- R1: After reset both ports drive rdata zero with rvld low, and both burst counters hold address 0. A port access with no counter control after reset targets address 0.
- R2: Both ports can access different addresses in the same cycle. Each port's read returns the word last written to its address, by either port.
- R3: If both ports write the same address in the same cycle, port A's data is the one stored.
- R4: A read that meets a write to the same address from the other port in the same cycle returns the old contents. A later read returns the new word.
- R5: With pipe_mode=0 (flow-through), inputs captured at edge E give rdata and rvld=1 after edge E+1.
- R6: With pipe_mode=1 (pipelined), inputs captured at edge E give rdata and rvld=1 after edge E+2. After edge E+1, rvld is still 0.
- R7: With x_load=1, the access uses the address on x_addr, and the counter takes that address.
- R8: With x_adv=1, the access uses the counter value plus one and the counter keeps it. Back-to-back advances walk sequential words.
- R9: Advancing from the top address 2^ADDR_W-1 wraps the counter to address 0.
- R10: Counter control priority is x_clr (access address 0) over x_load over x_adv. With none of them set, the access reuses the held counter value and x_addr is ignored.
- R11: With x_en=0 in a cycle, nothing is written and the counter does not change. That cycle's output slot has rvld=0 and rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 selects flow-through reads |
| a_en | input | 1 | Port A enable; 0 powers the port down for the cycle |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_load | input | 1 | Port A counter load from a_addr |
| a_adv | input | 1 | Port A counter step by one |
| a_clr | input | 1 | Port A counter clear to zero |
| a_addr | input | ADDR_W | Port A address bus |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvld | output | 1 | Port A read data valid |
| b_en | input | 1 | Port B enable; 0 powers the port down for the cycle |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_load | input | 1 | Port B counter load from b_addr |
| b_adv | input | 1 | Port B counter step by one |
| b_clr | input | 1 | Port B counter clear to zero |
| b_addr | input | ADDR_W | Port B address bus |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvld | output | 1 | Port B read data valid |

## Verification
The access path is driven as a back-to-back stream on port A. The stream mixes loaded writes and reads, advancing bursts, held-counter reads with a changing address bus, a wrap through the top address, and combined clear, load and advance controls. Each read value tells which counter source won. Reading through the other port, and issuing simultaneous writes to equal and unequal addresses, separates true two-port storage from port-A-wins collisions and from read-old-data overlap. The same read is observed one edge apart in the two output modes to tell the flow-through latency from the pipelined latency. A disabled cycle, followed by a read whose result depends on the counter, shows that the disabled cycle touched neither memory nor counter.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_STEP = 2'd1,
      OP_LOAD = 2'd2,
      OP_ZERO = 2'd3
   } cnt_op_e;

   // clear beats load, load beats step
   function automatic cnt_op_e pick_op(input logic clr, input logic load, input logic adv);
      if (clr)       return OP_ZERO;
      else if (load) return OP_LOAD;
      else if (adv)  return OP_STEP;
      else           return OP_HOLD;
   endfunction
endpackage

// File: rtl/dbs_port_front.sv
module dbs_port_front
   import dbs_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic              load,
   input  logic              adv,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_wr,
   output logic              acc_rd,
   output logic [DATA_W-1:0] acc_wdata
);
   logic              en_q, wr_q, load_q, adv_q, clr_q;
   logic [ADDR_W-1:0] addr_q, cnt_q, nxt;
   logic [DATA_W-1:0] wdata_q;
   cnt_op_e           op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         wr_q    <= 1'b0;
         load_q  <= 1'b0;
         adv_q   <= 1'b0;
         clr_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         cnt_q   <= '0;
      end else begin
         en_q    <= en;
         wr_q    <= wr;
         load_q  <= load;
         adv_q   <= adv;
         clr_q   <= clr;
         addr_q  <= addr;
         wdata_q <= wdata;
         if (en_q) cnt_q <= nxt;
      end
   end

   always_comb begin
      op = pick_op(clr_q, load_q, adv_q);
      unique case (op)
         OP_ZERO: nxt = '0;
         OP_LOAD: nxt = addr_q;
         OP_STEP: nxt = cnt_q + ADDR_W'(1);
         default: nxt = cnt_q;
      endcase
   end

   assign acc_addr  = nxt;
   assign acc_wr    = en_q & wr_q;
   assign acc_rd    = en_q & ~wr_q;
   assign acc_wdata = wdata_q;

   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && clr_q) |=> (cnt_q == '0));
   a_r7_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !clr_q && load_q) |=> (cnt_q == $past(addr_q)));
   a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !clr_q && !load_q && adv_q) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));
   a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !clr_q && !load_q && adv_q && (&cnt_q)) |=> (cnt_q == '0));
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || !(clr_q || load_q || adv_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/dbs_array.sv
module dbs_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] wd_a,
   input  logic              wr_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] wd_b,
   output logic [DATA_W-1:0] q_a,
   output logic [DATA_W-1:0] q_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // B is written first so that A overrides it on a shared address;
   // reads sample the word as it was before this edge
   always_ff @(posedge clk) begin
      if (wr_b) mem[addr_b] <= wd_b;
      if (wr_a) mem[addr_a] <= wd_a;
      q_a <= mem[addr_a];
      q_b <= mem[addr_b];
   end

   a_r3_port_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && wr_b && addr_a == addr_b) |=> (mem[$past(addr_a)] == $past(wd_a)));
endmodule

// File: rtl/dbs_out_stage.sv
module dbs_out_stage #(
   parameter int DATA_W   = 36,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              rd_fire,
   input  logic [DATA_W-1:0] arr_q,
   output logic [DATA_W-1:0] rdata,
   output logic              rvld
);
   logic              raw_vld;
   logic [DATA_W-1:0] flow_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_vld <= 1'b0;
      else        raw_vld <= rd_fire;
   end

   assign flow_d = raw_vld ? arr_q : '0;

   if (HAS_PIPE) begin : g_pipe
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= raw_vld;
            dat_q <= flow_d;
         end
      end
      assign rvld  = pipe_mode ? vld_q : raw_vld;
      assign rdata = pipe_mode ? dat_q : flow_d;

      a_r6_pipe_lag: assert property (@(posedge clk) disable iff (!rst_n)
         (pipe_mode && $past(pipe_mode)) |-> (rvld == $past(raw_vld)));
   end else begin : g_flow
      assign rvld  = raw_vld;
      assign rdata = flow_d;
   end
endmodule

// File: rtl/dual_burst_sram.sv
module dual_burst_sram #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 36,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              a_en,
   input  logic              a_wr,
   input  logic              a_load,
   input  logic              a_adv,
   input  logic              a_clr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_rvld,
   input  logic              b_en,
   input  logic              b_wr,
   input  logic              b_load,
   input  logic              b_adv,
   input  logic              b_clr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_rvld
);
   localparam int NPORT = 2;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("dual_burst_sram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_burst_sram: DATA_W must be positive");
   end

   logic [NPORT-1:0]             en_v, wr_v, load_v, adv_v, clr_v;
   logic [NPORT-1:0][ADDR_W-1:0] addr_v, acc_addr_v;
   logic [NPORT-1:0][DATA_W-1:0] wdata_v, acc_wd_v, arr_q_v, rdata_v;
   logic [NPORT-1:0]             acc_wr_v, acc_rd_v, rvld_v;

   assign en_v    = {b_en,    a_en};
   assign wr_v    = {b_wr,    a_wr};
   assign load_v  = {b_load,  a_load};
   assign adv_v   = {b_adv,   a_adv};
   assign clr_v   = {b_clr,   a_clr};
   assign addr_v  = {b_addr,  a_addr};
   assign wdata_v = {b_wdata, a_wdata};

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dbs_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) front_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (en_v[p]),
         .wr       (wr_v[p]),
         .load     (load_v[p]),
         .adv      (adv_v[p]),
         .clr      (clr_v[p]),
         .addr     (addr_v[p]),
         .wdata    (wdata_v[p]),
         .acc_addr (acc_addr_v[p]),
         .acc_wr   (acc_wr_v[p]),
         .acc_rd   (acc_rd_v[p]),
         .acc_wdata(acc_wd_v[p])
      );
      dbs_out_stage #(.DATA_W(DATA_W), .HAS_PIPE(HAS_PIPE)) out_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .pipe_mode(pipe_mode),
         .rd_fire  (acc_rd_v[p]),
         .arr_q    (arr_q_v[p]),
         .rdata    (rdata_v[p]),
         .rvld     (rvld_v[p])
      );
   end

   dbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_a  (acc_wr_v[0]),
      .addr_a(acc_addr_v[0]),
      .wd_a  (acc_wd_v[0]),
      .wr_b  (acc_wr_v[1]),
      .addr_b(acc_addr_v[1]),
      .wd_b  (acc_wd_v[1]),
      .q_a   (arr_q_v[0]),
      .q_b   (arr_q_v[1])
   );

   assign a_rdata = rdata_v[0];
   assign a_rvld  = rvld_v[0];
   assign b_rdata = rdata_v[1];
   assign b_rvld  = rvld_v[1];
endmodule

// File: tb/dual_burst_sram_tb_top.sv
`timescale 1ns/1ps
module dual_burst_sram_tb_top;
   localparam int AW = 10;
   localparam int DW = 36;

   typedef struct packed {
      logic          en, wr, load, adv, clr;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic          ev;
      logic [DW-1:0] ed;
   } vec_t;

   // port A stream in flow-through mode; the expected pair of entry i is seen one entry later
   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,1'b1,1'b0,1'b0, 10'd5,    36'h111, 1'b0, 36'h0},   // R7 write @5
      '{1'b1,1'b1,1'b0,1'b1,1'b0, 10'd0,    36'h222, 1'b0, 36'h0},   // R8 write @6
      '{1'b1,1'b1,1'b0,1'b1,1'b0, 10'd0,    36'h333, 1'b0, 36'h0},   // R8 write @7
      '{1'b1,1'b0,1'b1,1'b0,1'b0, 10'd5,    36'h0,   1'b1, 36'h111}, // R7 read @5
      '{1'b1,1'b0,1'b0,1'b1,1'b0, 10'd0,    36'h0,   1'b1, 36'h222}, // R8 read @6
      '{1'b1,1'b0,1'b0,1'b1,1'b0, 10'd0,    36'h0,   1'b1, 36'h333}, // R8 read @7
      '{1'b1,1'b0,1'b0,1'b0,1'b0, 10'd9,    36'h0,   1'b1, 36'h333}, // R10 hold, bus ignored
      '{1'b1,1'b1,1'b0,1'b0,1'b1, 10'd9,    36'h444, 1'b0, 36'h0},   // R10 clear, write @0
      '{1'b1,1'b1,1'b1,1'b0,1'b0, 10'd1023, 36'h555, 1'b0, 36'h0},   // R9 write @1023
      '{1'b1,1'b1,1'b0,1'b1,1'b0, 10'd0,    36'h666, 1'b0, 36'h0},   // R9 wrap write @0
      '{1'b1,1'b0,1'b1,1'b0,1'b0, 10'd1023, 36'h0,   1'b1, 36'h555}, // R9 read @1023
      '{1'b1,1'b0,1'b0,1'b1,1'b0, 10'd0,    36'h0,   1'b1, 36'h666}, // R9 wrap read @0
      '{1'b1,1'b0,1'b1,1'b1,1'b1, 10'd5,    36'h0,   1'b1, 36'h666}, // R10 clear beats all
      '{1'b1,1'b0,1'b1,1'b1,1'b0, 10'd5,    36'h0,   1'b1, 36'h111}, // R10 load beats adv
      '{1'b0,1'b1,1'b1,1'b0,1'b0, 10'd6,    36'hBAD, 1'b0, 36'h0},   // R11 disabled
      '{1'b1,1'b0,1'b0,1'b1,1'b0, 10'd0,    36'h0,   1'b1, 36'h222}, // R11 counter was 5
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 10'd0,    36'h0,   1'b0, 36'h0}    // idle
   };

   logic          clk = 1'b0;
   logic          rst_n, pipe_mode;
   logic          a_en, a_wr, a_load, a_adv, a_clr;
   logic          b_en, b_wr, b_load, b_adv, b_clr;
   logic [AW-1:0] a_addr, b_addr;
   logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
   logic          a_rvld, b_rvld;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dual_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
      .a_en(a_en), .a_wr(a_wr), .a_load(a_load), .a_adv(a_adv), .a_clr(a_clr),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvld(a_rvld),
      .b_en(b_en), .b_wr(b_wr), .b_load(b_load), .b_adv(b_adv), .b_clr(b_clr),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvld(b_rvld)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drv_a(input logic en, wr, load, adv, clr,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      a_en = en; a_wr = wr; a_load = load; a_adv = adv; a_clr = clr;
      a_addr = ad; a_wdata = wd;
   endtask

   task automatic drv_b(input logic en, wr, load, adv, clr,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      b_en = en; b_wr = wr; b_load = load; b_adv = adv; b_clr = clr;
      b_addr = ad; b_wdata = wd;
   endtask

   task automatic idle();
      drv_a(0, 0, 0, 0, 0, '0, '0);
      drv_b(0, 0, 0, 0, 0, '0, '0);
   endtask

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      pipe_mode = 1'b0;
      idle();
      step(); step(); step();
      rst_n = 1'b1;
      step();

      chk("R1 a_rvld after reset", DW'(a_rvld), '0);
      chk("R1 a_rdata after reset", a_rdata, '0);
      chk("R1 b_rvld after reset", DW'(b_rvld), '0);
      chk("R1 b_rdata after reset", b_rdata, '0);

      // R1: write with no counter control lands at address 0
      drv_a(1, 1, 0, 0, 0, 10'd77, 36'h77);
      step();
      drv_a(0, 0, 0, 0, 0, '0, '0);
      drv_b(1, 0, 1, 0, 0, 10'd0, '0);
      step();
      idle();
      step();
      chk("R1 counter starts at 0", b_rdata, 36'h77);
      chk("R5 flow b_rvld", DW'(b_rvld), 36'h1);

      // vector stream, R5 flow-through latency of one edge
      for (int i = 0; i < NV; i++) begin
         drv_a(VECS[i].en, VECS[i].wr, VECS[i].load, VECS[i].adv, VECS[i].clr,
               VECS[i].addr, VECS[i].wd);
         step();
         if (i > 0) begin
            chk($sformatf("R5 vec %0d a_rvld", i-1), DW'(a_rvld), DW'(VECS[i-1].ev));
            chk($sformatf("R5 vec %0d a_rdata", i-1), a_rdata, VECS[i-1].ed);
         end
      end
      idle();
      step();
      chk("R11 last vec a_rvld", DW'(a_rvld), DW'(VECS[NV-1].ev));
      chk("R11 last vec a_rdata", a_rdata, VECS[NV-1].ed);

      // R2: both ports write, then cross read
      drv_a(1, 1, 1, 0, 0, 10'd20, 36'hAAA);
      drv_b(1, 1, 1, 0, 0, 10'd21, 36'hBBB);
      step();
      drv_a(1, 0, 1, 0, 0, 10'd21, '0);
      drv_b(1, 0, 1, 0, 0, 10'd20, '0);
      step();
      idle();
      step();
      chk("R2 a reads b word", a_rdata, 36'hBBB);
      chk("R2 b reads a word", b_rdata, 36'hAAA);
      chk("R2 both valid", DW'({a_rvld, b_rvld}), 36'h3);

      // R3: same-address write collision
      drv_a(1, 1, 1, 0, 0, 10'd30, 36'h1);
      drv_b(1, 1, 1, 0, 0, 10'd30, 36'h2);
      step();
      idle();
      drv_b(1, 0, 1, 0, 0, 10'd30, '0);
      step();
      idle();
      step();
      chk("R3 port A wins", b_rdata, 36'h1);

      // R4: read meets other-port write
      drv_a(1, 1, 1, 0, 0, 10'd5, 36'h999);
      drv_b(1, 0, 1, 0, 0, 10'd5, '0);
      step();
      idle();
      step();
      chk("R4 old data on overlap", b_rdata, 36'h111);
      drv_b(1, 0, 1, 0, 0, 10'd5, '0);
      step();
      idle();
      step();
      chk("R4 new data later", b_rdata, 36'h999);

      // R6: pipelined latency of two edges
      pipe_mode = 1'b1;
      step(); step();
      chk("R11 pipe idle rvld", DW'(a_rvld), '0);
      drv_a(1, 0, 1, 0, 0, 10'd5, '0);
      step();
      idle();
      step();
      chk("R6 not yet valid", DW'(a_rvld), '0);
      chk("R6 not yet data", a_rdata, '0);
      step();
      chk("R6 pipe valid", DW'(a_rvld), 36'h1);
      chk("R6 pipe data", a_rdata, 36'h999);
      step();
      chk("R11 pipe off again", DW'(a_rvld), '0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule